// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit processor core. It collects five interrupt causes: two external request pins that trigger on a rising edge, a port-level input that is active while it is held, a timer overflow pulse and a comparator event pulse. Each cause latches into a pending flag. A flag becomes a request to the core only when its own enable bit is set and the global interrupt enable is set. The highest-priority enabled pending cause is turned into a handler vector number. Vector 0 belongs to reset and always wins.

The core accepts an interrupt by pulsing `irq_ack_i` while `irq_req_o` is high. On that edge the controller clears the winning flag and drops the global enable, which masks all further requests. The global enable comes back when the core pulses `irq_reti_i`. Software can also set it from inside a handler to allow nesting.

Software reaches three registers through a simple write/read port. The control register at address 0 holds the global enable in bit 0. The enable register at address 1 holds the per-cause enables in bits 4:0. The flag register at address 2 reads the pending flags in bits 4:0, and writing a one to a bit clears that flag. Address 3 reads zero and ignores writes.

The global enable is kept by a two-state machine:
- States: `GIE_MASKED` (the reset state, no request can reach the core) and `GIE_ARMED`.
- `T_TAKE` moves ARMED to MASKED on an accepted acknowledge.
- `T_SW_CLR` moves ARMED to MASKED on a control write of 0.
- `T_RETURN` moves MASKED to ARMED on a return event.
- `T_SW_SET` moves MASKED to ARMED on a control write of 1.
- In ARMED, an acknowledge outranks a return, and a return outranks a software write. In MASKED, a return outranks a software write.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq_vector_o` is 0 and `irq_req_o` is 0 at once, without waiting for a clock. After reset, the control, enable and flag registers all read 0.
- R2: The external request sources use flag bit 0 (request 0) and flag bit 1 (request 1). Each passes through a two-flop synchronizer. A rising input sets its flag on the third clock edge after the input rises. An input that stays high does not set the flag again.
- R3: The timer overflow (flag bit 3) and comparator (flag bit 4) inputs set their flags on the clock edge at which the input pulse is high.
- R4: The port-level flag (bit 2) follows its input after a two-flop synchronizer, so it changes on the second edge. Writing one to it and accepting it as a vector leave it unchanged.
- R5: Writing to address 2 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: When a source event and a write-one-to-clear hit the same flag on the same edge, the flag stays set.
- R7: `irq_req_o` is 1 exactly when some flag has its enable bit (address 1, same bit position) set and the global enable (address 0, bit 0) is 1.
- R8: When a request is raised, `irq_vector_o` is 1 + the lowest flag bit index among enabled pending flags. Priority order is request 0, request 1, port level, timer, comparator. The output is 0 when there is no request.
- R9: An acknowledge while `irq_req_o` is high clears the global enable and the winning flag on that edge. It outranks a same-cycle software write of 1 to the global enable.
- R10: A return pulse sets the global enable to 1, and it outranks a same-cycle software write of 0.
- R11: Software may set the global enable inside a handler, which lets a second acknowledge take a pending request (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset request, active low, forces vector 0 |
| ext_req0_i | input | 1 | External request 0, rising-edge triggered |
| ext_req1_i | input | 1 | External request 1, rising-edge triggered |
| port_low_i | input | 1 | Port low-level detect, high while the port is low |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| cmp_evt_i | input | 1 | Comparator event pulse |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_ack_i | input | 1 | Core acknowledges the current request |
| irq_reti_i | input | 1 | Core returns from an interrupt handler |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vector_o | output | 3 | Handler vector number |

## Verification
The request and vector outputs are exercised under several patterns:
- A single enabled flag.
- A pending flag that is masked by its enable bit.
- A pending flag that is masked by the global enable.
- Several flags pending together, which separates a correct priority order from a reversed or unmasked one.

Same-edge collisions are driven on purpose. These are an event against a write-one-to-clear, a return against a software clear, and an acknowledge against a software set. They tell a correct arbitration order apart from a plausible but wrong one.

The edge sources are held high for a long time, and the level source is written to and acknowledged. This separates edge latching from level following.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_COUNT = 5;
    localparam int REG_DW    = 8;
    localparam int REG_AW    = 2;
    localparam int VEC_W     = $clog2(SRC_COUNT + 1);

    // bit i of a source vector: 0 ext req 0, 1 ext req 1, 2 port level,
    // 3 timer overflow, 4 comparator (also the priority order)
    localparam logic [SRC_COUNT-1:0] LEVEL_SRCS = 5'b00100;
    localparam logic [SRC_COUNT-1:0] EDGE_SRCS  = 5'b00011;
    localparam logic [VEC_W-1:0]     RESET_VEC  = '0;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 2'd0,
        RA_MASK  = 2'd1,
        RA_FLAG  = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        GIE_MASKED = 1'b0,
        GIE_ARMED  = 1'b1
    } gie_state_e;
endpackage

// File: rtl/irqc_front.sv
module irqc_front #(
    parameter int N = 5,
    parameter logic [N-1:0] LVL = '0,
    parameter logic [N-1:0] EDG = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] set_o,
    output logic [N-1:0] lvl_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_src
        if (LVL[gi]) begin : g_level
            logic [1:0] sq;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sq <= '0;
                else        sq <= {sq[0], raw_i[gi]};
            end
            assign lvl_o[gi] = sq[1];
            assign set_o[gi] = 1'b0;
        end else if (EDG[gi]) begin : g_edge
            // sq[0], sq[1]: synchronizer; sq[2]: previous synchronized value
            logic [2:0] sq;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sq <= '0;
                else        sq <= {sq[1:0], raw_i[gi]};
            end
            assign set_o[gi] = sq[1] & ~sq[2];
            assign lvl_o[gi] = 1'b0;
        end else begin : g_pulse
            assign set_o[gi] = raw_i[gi];
            assign lvl_o[gi] = 1'b0;
        end
    end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int N = 5,
    parameter logic [N-1:0] LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] clr_hw_i,
    output logic [N-1:0] flag_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_flag
        if (LVL[gi]) begin : g_follow
            logic follow_unused;
            assign follow_unused = set_i[gi] ^ w1c_i[gi] ^ clr_hw_i[gi];
            assign flag_o[gi] = lvl_i[gi];
        end else begin : g_latch
            logic latch_unused;
            logic fq;
            assign latch_unused = lvl_i[gi];
            // a new event outranks both kinds of clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          fq <= 1'b0;
                else if (set_i[gi])                  fq <= 1'b1;
                else if (w1c_i[gi] || clr_hw_i[gi])  fq <= 1'b0;
            end
            assign flag_o[gi] = fq;

            p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[gi] |=> flag_o[gi]);
            p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (w1c_i[gi] && !set_i[gi]) |=> !flag_o[gi]);
            p_take_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hw_i[gi] && !set_i[gi]) |=> !flag_o[gi]);
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N  = 5,
    parameter int VW = 3
) (
    input  logic [N-1:0]  pending_i,
    output logic          any_o,
    output logic [VW-1:0] vec_o
);
    always_comb begin
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending_i[i]) vec_o = VW'(i + 1);
        end
        any_o = |pending_i;
    end
endmodule

// File: rtl/irqc_gie_fsm.sv
module irqc_gie_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic reti_i,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    output logic gie_o
);
    gie_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GIE_MASKED;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            GIE_ARMED: begin
                if (take_i)                    nxt = GIE_MASKED;  // T_TAKE
                else if (reti_i)               nxt = GIE_ARMED;
                else if (sw_wr_i && !sw_val_i) nxt = GIE_MASKED;  // T_SW_CLR
            end
            GIE_MASKED: begin
                if (reti_i)                    nxt = GIE_ARMED;   // T_RETURN
                else if (sw_wr_i && sw_val_i)  nxt = GIE_ARMED;   // T_SW_SET
            end
        endcase
    end

    always_comb begin
        gie_o = (st == GIE_ARMED);
    end

    p_take_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !gie_o);
    p_reti_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !take_i) |=> gie_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req0_i,
    input  logic              ext_req1_i,
    input  logic              port_low_i,
    input  logic              tmr_ovf_i,
    input  logic              cmp_evt_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic              irq_ack_i,
    input  logic              irq_reti_i,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  irq_vector_o
);
    localparam int N = SRC_COUNT;

    logic [N-1:0]     raw, set_evt, lvl, w1c, clr_hw, flag, mask_q, pending;
    logic [VEC_W-1:0] win_vec;
    logic             any_pend, gie, take, wr_ctrl, wr_mask, wr_flag;
    logic             wdata_unused;

    assign raw          = {cmp_evt_i, tmr_ovf_i, port_low_i, ext_req1_i, ext_req0_i};
    assign wr_ctrl      = reg_wr_i && (reg_addr_i == RA_CTRL);
    assign wr_mask      = reg_wr_i && (reg_addr_i == RA_MASK);
    assign wr_flag      = reg_wr_i && (reg_addr_i == RA_FLAG);
    assign w1c          = wr_flag ? reg_wdata_i[N-1:0] : '0;
    assign wdata_unused = ^reg_wdata_i[REG_DW-1:N];

    irqc_front #(.N(N), .LVL(LEVEL_SRCS), .EDG(EDGE_SRCS)) u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .set_o (set_evt),
        .lvl_o (lvl)
    );

    irqc_flags #(.N(N), .LVL(LEVEL_SRCS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_evt),
        .lvl_i    (lvl),
        .w1c_i    (w1c),
        .clr_hw_i (clr_hw),
        .flag_o   (flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata_i[N-1:0];
    end

    assign pending = flag & mask_q;

    irqc_prio #(.N(N), .VW(VEC_W)) u_prio (
        .pending_i (pending),
        .any_o     (any_pend),
        .vec_o     (win_vec)
    );

    irqc_gie_fsm u_gie (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .reti_i   (irq_reti_i),
        .sw_wr_i  (wr_ctrl),
        .sw_val_i (reg_wdata_i[0]),
        .gie_o    (gie)
    );

    assign irq_req_o    = any_pend && gie;
    assign take         = irq_ack_i && irq_req_o;
    assign irq_vector_o = (rst_n && irq_req_o) ? win_vec : RESET_VEC;

    // the vector seen on the acknowledge edge selects the flag to drop
    always_comb begin
        for (int i = 0; i < N; i++) begin
            clr_hw[i] = take && (win_vec == VEC_W'(i + 1));
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_e'(reg_addr_i))
            RA_CTRL:  reg_rdata_o[0]   = gie;
            RA_MASK:  reg_rdata_o[N-1:0] = mask_q;
            RA_FLAG:  reg_rdata_o[N-1:0] = flag;
            RA_SPARE: reg_rdata_o      = '0;
        endcase
    end

    p_vector_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_vector_o != RESET_VEC));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/100ps
module irq_vector_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_req0 = 0, ext_req1 = 0, port_low = 0, tmr_ovf = 0, cmp_evt = 0;
    logic [1:0] reg_addr = 2'd2;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_ack = 0, irq_reti = 0;
    logic       irq_req;
    logic [2:0] irq_vector;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req0_i   (ext_req0),
        .ext_req1_i   (ext_req1),
        .port_low_i   (port_low),
        .tmr_ovf_i    (tmr_ovf),
        .cmp_evt_i    (cmp_evt),
        .reg_addr_i   (reg_addr),
        .reg_wr_i     (reg_wr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .irq_ack_i    (irq_ack),
        .irq_reti_i   (irq_reti),
        .irq_req_o    (irq_req),
        .irq_vector_o (irq_vector)
    );

    // ---------------- behavioural reference model ----------------
    bit       m_gie;
    bit [4:0] m_en, m_flag;
    bit       q_e0[$], q_e1[$], q_pl[$];

    function automatic int m_winner();
        int w = -1;
        for (int i = 4; i >= 0; i--) if (m_flag[i] && m_en[i]) w = i;
        return w;
    endfunction

    function automatic bit m_req();
        return (m_winner() >= 0) && m_gie;
    endfunction

    function automatic logic [2:0] m_vec();
        return m_req() ? 3'(m_winner() + 1) : 3'd0;
    endfunction

    function automatic logic [7:0] m_rd(logic [1:0] a);
        case (a)
            2'd0:    return {7'd0, m_gie};
            2'd1:    return {3'd0, m_en};
            2'd2:    return {3'd0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gie = 0; m_en = 0; m_flag = 0;
            q_e0.delete(); q_e1.delete(); q_pl.delete();
            repeat (3) begin q_e0.push_back(0); q_e1.push_back(0); q_pl.push_back(0); end
        end else begin
            int  w;
            bit  tk;
            bit [4:0] ev, clr;
            w  = m_winner();
            tk = irq_ack && m_req();
            ev = {cmp_evt, tmr_ovf, 1'b0, q_e1[1] && !q_e1[2], q_e0[1] && !q_e0[2]};
            clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata[4:0] : 5'd0;
            for (int i = 0; i < 5; i++) begin
                if (i != 2) begin
                    if (ev[i]) m_flag[i] = 1;
                    else if (clr[i] || (tk && w == i)) m_flag[i] = 0;
                end
            end
            q_e0.push_front(ext_req0); void'(q_e0.pop_back());
            q_e1.push_front(ext_req1); void'(q_e1.pop_back());
            q_pl.push_front(port_low); void'(q_pl.pop_back());
            m_flag[2] = q_pl[1];
            if (tk) m_gie = 0;
            else if (irq_reti) m_gie = 1;
            else if (reg_wr && reg_addr == 2'd0) m_gie = reg_wdata[0];
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata[4:0];
        end
    end

    // model compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            ntests++;
            if (irq_req !== m_req() || irq_vector !== m_vec() || reg_rdata !== m_rd(reg_addr)) begin
                nfail++;
                $display("FAIL R7 R8 model compare: act req=%0b vec=%0d rd=%02h exp req=%0b vec=%0d rd=%02h",
                         irq_req, irq_vector, reg_rdata, m_req(), m_vec(), m_rd(reg_addr));
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #0.5;
    endtask

    task automatic rdchk(input logic [1:0] a, input string tag, input logic [7:0] exp);
        reg_addr = a;
        #0.3;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        cyc();
        reg_wr = 0; reg_addr = 2'd2;
    endtask

    initial begin
        repeat (3) cyc();
        chk("R1 vector in reset", {5'd0, irq_vector}, 8'd0);
        chk("R1 req in reset", {7'd0, irq_req}, 8'd0);
        rst_n = 1;
        cyc();
        rdchk(0, "R1 ctrl after reset", 8'h00);
        rdchk(1, "R1 enable after reset", 8'h00);
        rdchk(2, "R1 flags after reset", 8'h00);

        tmr_ovf = 1; cyc(); tmr_ovf = 0;
        rdchk(2, "R3 timer flag", 8'h08);
        chk("R7 no req, enable clear", {7'd0, irq_req}, 8'd0);
        wr(1, 8'h08);
        chk("R7 no req, global clear", {7'd0, irq_req}, 8'd0);
        wr(0, 8'h01);
        chk("R7 req raised", {7'd0, irq_req}, 8'd1);
        chk("R8 timer vector", {5'd0, irq_vector}, 8'd4);

        ext_req0 = 1;
        cyc(); cyc();
        rdchk(2, "R2 not yet after two edges", 8'h08);
        cyc();
        rdchk(2, "R2 set on third edge", 8'h09);
        chk("R8 disabled source ignored", {5'd0, irq_vector}, 8'd4);
        wr(1, 8'h09);
        chk("R8 ext0 outranks timer", {5'd0, irq_vector}, 8'd1);

        irq_ack = 1; cyc(); irq_ack = 0;
        rdchk(0, "R9 ack clears global", 8'h00);
        rdchk(2, "R9 ack clears winner only", 8'h08);
        chk("R9 req masked after ack", {7'd0, irq_req}, 8'd0);

        wr(0, 8'h01);
        chk("R11 nested enable vector", {5'd0, irq_vector}, 8'd4);
        irq_ack = 1; cyc(); irq_ack = 0;
        rdchk(2, "R11 nested take clears timer", 8'h00);
        rdchk(0, "R11 global cleared again", 8'h00);
        irq_reti = 1; cyc(); irq_reti = 0;
        rdchk(0, "R10 return sets global", 8'h01);

        tmr_ovf = 1; cmp_evt = 1; cyc(); tmr_ovf = 0; cmp_evt = 0;
        rdchk(2, "R3 timer and comparator", 8'h18);
        wr(2, 8'h10);
        rdchk(2, "R5 w1c keeps zero bits", 8'h08);
        reg_addr = 2; reg_wdata = 8'h08; reg_wr = 1; tmr_ovf = 1;
        cyc();
        reg_wr = 0; tmr_ovf = 0;
        rdchk(2, "R6 event beats w1c", 8'h08);
        rdchk(2, "R2 held input no retrigger", 8'h08);

        port_low = 1; cyc();
        rdchk(2, "R4 level not after one edge", 8'h08);
        cyc();
        rdchk(2, "R4 level after two edges", 8'h0C);
        wr(2, 8'h04);
        rdchk(2, "R4 w1c ignored on level", 8'h0C);
        wr(1, 8'h0D);
        chk("R8 port outranks timer", {5'd0, irq_vector}, 8'd3);
        irq_ack = 1; cyc(); irq_ack = 0;
        rdchk(2, "R4 ack leaves level flag", 8'h0C);
        rdchk(0, "R9 global cleared", 8'h00);
        port_low = 0; cyc(); cyc();
        rdchk(2, "R4 level released", 8'h08);

        reg_addr = 0; reg_wdata = 8'h00; reg_wr = 1; irq_reti = 1;
        cyc();
        reg_wr = 0; irq_reti = 0;
        rdchk(0, "R10 return beats write 0", 8'h01);
        reg_addr = 0; reg_wdata = 8'h01; reg_wr = 1; irq_ack = 1;
        cyc();
        reg_wr = 0; irq_ack = 0;
        rdchk(0, "R9 ack beats write 1", 8'h00);
        rdchk(2, "R9 timer winner cleared", 8'h00);

        wr(1, 8'h1F); wr(0, 8'h01);
        ext_req1 = 1; cyc(); cyc(); cyc();
        rdchk(2, "R2 ext1 flag", 8'h02);
        chk("R8 ext1 vector", {5'd0, irq_vector}, 8'd2);
        cmp_evt = 1; cyc(); cmp_evt = 0;
        chk("R8 ext1 outranks comparator", {5'd0, irq_vector}, 8'd2);

        rst_n = 0;
        #0.3;
        chk("R1 async vector", {5'd0, irq_vector}, 8'd0);
        chk("R1 async req", {7'd0, irq_req}, 8'd0);
        cyc();
        rst_n = 1;
        cyc();
        rdchk(0, "R1 global after mid reset", 8'h00);
        repeat (5) cyc();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            ntests++;
            nfail++;
            $display("FAIL watchdog all requirements act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule